// File: doc/BRIEF.md
# Serial Register Port for an Eight-Channel Switch Controller

This block is the serial configuration port of an eight-channel low-side switch controller. A host drives a four-wire serial bus (clock, chip select, data in, data out) in 16-bit frames. Each frame may write one of six per-channel configuration registers. Each frame also returns a 16-bit response made of the latched diagnosis bits and the contents of the register that the previous frame named. The register contents go straight to the channel logic. The live on/off state of the eight output transistors comes back in as a read-only register.

The serial inputs are asynchronous to the system clock. They pass through a two-flop synchroniser and are edge-detected in the `clk` domain. A small state machine sequences each transfer. ST_IDLE waits for chip select. On a chip-select fall it takes the transition IDLE->ACTIVE and preloads the response into the shift register. ST_ACTIVE samples data on clock rising edges and shifts on falling edges. On a chip-select rise it takes the transition ACTIVE->COMMIT. ST_COMMIT decides whether the frame was complete and writes or updates the read pointer. It always takes COMMIT->IDLE on the next cycle. Because the response is shifted out ahead of the received bits, any bit clocked past the first 16 reappears on the data output 16 clocks later, so several devices can be chained.

Register addresses (frame bits 14:12) are 001 input mapping, 010 boolean operation, 011 overload behaviour, 100 overtemperature behaviour, 101 slew rate, 110 output state (read-only, live input), and 111 serial control. Bit 0 of every register belongs to channel 1 and bit 7 to channel 8.

Top module: `sw_spi_regs`

## Requirements
- R1: While `rst_n` is low and after it is released, the input-mapping register reads 08h, the other five writable registers read 00h, `so_oe` is 0 and the read pointer is 000.
- R2: `so_oe` is 0 whenever chip select has been high for more than the synchroniser delay, and 1 during a transfer once the chip-select fall has been seen; `so_d` is 0 while `so_oe` is 0.
- R3: A frame is shifted most significant bit first: bit 15 = write flag (1 = write), bits 14:12 = address, bits 7:0 = data. A complete write frame loads bits 7:0 into the addressed register after chip select rises.
- R4: Frame bits 11:8 have no effect on the written value.
- R5: A transfer whose number of clock pulses is zero or not a multiple of 16 changes no register and leaves the read pointer unchanged.
- R6: A write frame addressed to 000 or 110 changes no register.
- R7: The first 16 bits on `so_d` are {diag_i[7:0], readback[7:0]} MSB first, sampled at the chip-select fall. Readback is the register named by the last complete frame: `out_state_i` for 110, 00h for 000.
- R8: Bits clocked after the first 16 of a transfer appear on `so_d` as the `si` bits received 16 clocks earlier. For a transfer of 16·k clocks only the last 16 bits received are decoded.
- R9: Register outputs change only in the cycle after a committed write, and never during a transfer.
- R10: `so_d` changes only after a falling edge of `sclk` (or at the response preload), so it is stable across each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idle low, asynchronous |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| si | input | 1 | Serial data in |
| so_d | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the tri-state data-out pad |
| out_state_i | input | 8 | Live on/off state of each output transistor |
| diag_i | input | 8 | Latched diagnosis bits, one per channel |
| map_o | output | 8 | Input-mapping register |
| bool_o | output | 8 | Boolean-operation register (0 OR, 1 AND) |
| ovld_o | output | 8 | Overload-behaviour register |
| otmp_o | output | 8 | Overtemperature-behaviour register |
| slew_o | output | 8 | Slew-rate register |
| ctrl_o | output | 8 | Serial on/off control register |

## Verification
The assertions assume that `sclk` idles low when chip select changes. They also assume that every serial edge lasts several system clocks longer than the synchroniser delay, so that each rise, fall and chip-select edge is seen once and in order. The stimulus holds each `sclk` phase for eight system clocks and waits eight clocks around every chip-select edge. It changes `si` only while `sclk` is low, and changes `diag_i` and `out_state_i` only while chip select is high. Under these conditions the bench can predict every output bit and register value exactly.

// File: rtl/sw_spi_pkg.sv
package sw_spi_pkg;
    localparam int CH_N    = 8;
    localparam int ADDR_W  = 3;
    localparam int RSVD_W  = 4;
    localparam int FRAME_W = 1 + ADDR_W + RSVD_W + CH_N;
    localparam int ADDR_LSB = CH_N + RSVD_W;
    localparam int NREG    = (1 << ADDR_W) - 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_COMMIT = 2'd2
    } spi_state_e;

    typedef enum logic [ADDR_W-1:0] {
        A_NONE  = 3'd0,
        A_MAP   = 3'd1,
        A_BOOL  = 3'd2,
        A_OVLD  = 3'd3,
        A_OTMP  = 3'd4,
        A_SLEW  = 3'd5,
        A_STATE = 3'd6,
        A_CTRL  = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/sw_spi_sync.sv
module sw_spi_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    stage_q[s] <= RST_VAL;
                else if (s == 0)
                    stage_q[s] <= d;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sw_spi_shift.sv
module sw_spi_shift
    import sw_spi_pkg::*;
#(
    parameter int W = FRAME_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [W-1:0]      load_val,
    input  logic              sample,
    input  logic              shift,
    input  logic              si_bit,
    output logic              so_bit,
    output logic              frame_ok,
    output logic              f_wr,
    output logic [ADDR_W-1:0] f_addr,
    output logic [CH_N-1:0]   f_data
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sreg_q;
    logic          rx_q;
    logic [CW-1:0] cnt_q;
    logic          seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            rx_q   <= 1'b0;
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (load) begin
            sreg_q <= load_val;
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (sample)
                rx_q <= si_bit;
            if (shift) begin
                sreg_q <= {sreg_q[W-2:0], rx_q};
                seen_q <= 1'b1;
                cnt_q  <= (cnt_q == CW'(W-1)) ? '0 : cnt_q + 1'b1;
            end
        end
    end

    assign so_bit   = sreg_q[W-1];
    assign frame_ok = seen_q && (cnt_q == '0);
    assign f_wr     = sreg_q[W-1];
    assign f_addr   = sreg_q[ADDR_LSB +: ADDR_W];
    assign f_data   = sreg_q[CH_N-1:0];

    // R10
    so_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !load) |=> $stable(so_bit));
endmodule

// File: rtl/sw_spi_regfile.sv
module sw_spi_regfile
    import sw_spi_pkg::*;
#(
    parameter int NCH = CH_N,
    parameter logic [NCH-1:0] MAP_RST = NCH'(8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NCH-1:0]    wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NCH-1:0]    out_state,
    output logic [NCH-1:0]    rd_data,
    output logic [NCH-1:0]    map_o,
    output logic [NCH-1:0]    bool_o,
    output logic [NCH-1:0]    ovld_o,
    output logic [NCH-1:0]    otmp_o,
    output logic [NCH-1:0]    slew_o,
    output logic [NCH-1:0]    ctrl_o
);
    logic [NREG:1][NCH-1:0] regs_q;
    logic [NREG:1]          wr_hit;

    generate
        for (genvar a = 1; a <= NREG; a++) begin : g_reg
            if (a == int'(A_STATE)) begin : g_ro
                assign wr_hit[a] = 1'b0;
                assign regs_q[a] = out_state;
            end else begin : g_rw
                localparam logic [NCH-1:0] RV = (a == int'(A_MAP)) ? MAP_RST : '0;
                assign wr_hit[a] = wr_en && (wr_addr == ADDR_W'(a));
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        regs_q[a] <= RV;
                    else if (wr_hit[a])
                        regs_q[a] <= wr_data;
                end
            end
        end
    endgenerate

    always_comb begin
        if (rd_addr == A_NONE)
            rd_data = '0;
        else
            rd_data = regs_q[rd_addr];
    end

    assign map_o  = regs_q[A_MAP];
    assign bool_o = regs_q[A_BOOL];
    assign ovld_o = regs_q[A_OVLD];
    assign otmp_o = regs_q[A_OTMP];
    assign slew_o = regs_q[A_SLEW];
    assign ctrl_o = regs_q[A_CTRL];

    // R9
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({map_o, bool_o, ovld_o, otmp_o, slew_o, ctrl_o}));

    // R6
    ro_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == A_NONE || wr_addr == A_STATE))
            |=> $stable({map_o, bool_o, ovld_o, otmp_o, slew_o, ctrl_o}));

    // R3
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_hit));
endmodule

// File: rtl/sw_spi_regs.sv
module sw_spi_regs
    import sw_spi_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter logic [CH_N-1:0] MAP_RST = CH_N'(8)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk,
    input  logic            cs_n,
    input  logic            si,
    output logic            so_d,
    output logic            so_oe,
    input  logic [CH_N-1:0] out_state_i,
    input  logic [CH_N-1:0] diag_i,
    output logic [CH_N-1:0] map_o,
    output logic [CH_N-1:0] bool_o,
    output logic [CH_N-1:0] ovld_o,
    output logic [CH_N-1:0] otmp_o,
    output logic [CH_N-1:0] slew_o,
    output logic [CH_N-1:0] ctrl_o
);
    logic [2:0] sync_q;
    logic       cs_s, sclk_s, si_s;
    logic       cs_d, sclk_d;
    logic       cs_fall, cs_rise, sclk_rise, sclk_fall;

    spi_state_e state_q, state_d;

    logic              load_en, sample_en, shift_en, commit_en;
    logic              so_bit, frame_ok, f_wr;
    logic [ADDR_W-1:0] f_addr;
    logic [CH_N-1:0]   f_data;
    logic [ADDR_W-1:0] rd_ptr_q;
    logic [CH_N-1:0]   rd_data;

    sw_spi_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, si}),
        .q     (sync_q)
    );

    assign cs_s   = sync_q[2];
    assign sclk_s = sync_q[1];
    assign si_s   = sync_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_s;
            sclk_d <= sclk_s;
        end
    end

    assign cs_fall   =  cs_d  & ~cs_s;
    assign cs_rise   = ~cs_d  &  cs_s;
    assign sclk_rise = ~sclk_d &  sclk_s;
    assign sclk_fall =  sclk_d & ~sclk_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_fall) state_d = ST_ACTIVE;
            ST_ACTIVE: if (cs_rise) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        load_en   = 1'b0;
        sample_en = 1'b0;
        shift_en  = 1'b0;
        commit_en = 1'b0;
        so_oe     = 1'b0;
        unique case (state_q)
            ST_IDLE:   load_en = cs_fall;
            ST_ACTIVE: begin
                so_oe     = 1'b1;
                sample_en = sclk_rise;
                shift_en  = sclk_fall;
            end
            ST_COMMIT: commit_en = 1'b1;
            default:   ;
        endcase
    end

    assign so_d = so_oe & so_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_ptr_q <= A_NONE;
        else if (commit_en && frame_ok)
            rd_ptr_q <= f_addr;
    end

    sw_spi_shift #(.W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_en),
        .load_val ({diag_i, rd_data}),
        .sample   (sample_en),
        .shift    (shift_en),
        .si_bit   (si_s),
        .so_bit   (so_bit),
        .frame_ok (frame_ok),
        .f_wr     (f_wr),
        .f_addr   (f_addr),
        .f_data   (f_data)
    );

    sw_spi_regfile #(.NCH(CH_N), .MAP_RST(MAP_RST)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (commit_en && frame_ok && f_wr),
        .wr_addr   (f_addr),
        .wr_data   (f_data),
        .rd_addr   (rd_ptr_q),
        .out_state (out_state_i),
        .rd_data   (rd_data),
        .map_o     (map_o),
        .bool_o    (bool_o),
        .ovld_o    (ovld_o),
        .otmp_o    (otmp_o),
        .slew_o    (slew_o),
        .ctrl_o    (ctrl_o)
    );

    // R2
    so_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && cs_d) |-> (!so_oe && !so_d));

    // R5
    short_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT && !frame_ok) |=> $stable(rd_ptr_q));
endmodule

// File: tb/sw_spi_regs_tb.sv
module sw_spi_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic       so_d, so_oe;
    logic [7:0] out_state_i = 8'h00, diag_i = 8'h00;
    logic [7:0] map_o, bool_o, ovld_o, otmp_o, slew_o, ctrl_o;

    int vecs = 0;
    int errs = 0;

    logic [7:0] m_reg [8];
    int         m_ptr;
    logic       exp_so [$];
    logic       exp_oe = 1'b0;
    logic       cmp_en = 1'b0;

    always #10 clk = ~clk;

    sw_spi_regs u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si),
        .so_d(so_d), .so_oe(so_oe), .out_state_i(out_state_i), .diag_i(diag_i),
        .map_o(map_o), .bool_o(bool_o), .ovld_o(ovld_o), .otmp_o(otmp_o),
        .slew_o(slew_o), .ctrl_o(ctrl_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] frm(input logic wr, input int addr,
                                        input logic [3:0] rsvd, input logic [7:0] data);
        return {wr, 3'(addr), rsvd, data};
    endfunction

    function automatic logic [7:0] readback(input int p);
        if (p == 0) return 8'h00;
        if (p == 6) return out_state_i;
        return m_reg[p];
    endfunction

    task automatic model_reset();
        for (int a = 0; a < 8; a++) m_reg[a] = 8'h00;
        m_reg[1] = 8'h08;
        m_ptr = 0;
    endtask

    // reference compare on every clock (R9 registers, R2 enable)
    always @(negedge clk) begin
        if (cmp_en) begin
            vecs++;
            if ({map_o, bool_o, ovld_o, otmp_o, slew_o, ctrl_o} !==
                {m_reg[1], m_reg[2], m_reg[3], m_reg[4], m_reg[5], m_reg[7]}) begin
                errs++;
                $display("FAIL R9 regs act=%h exp=%h",
                    {map_o, bool_o, ovld_o, otmp_o, slew_o, ctrl_o},
                    {m_reg[1], m_reg[2], m_reg[3], m_reg[4], m_reg[5], m_reg[7]});
            end
            vecs++;
            if (so_oe !== exp_oe || (!exp_oe && so_d !== 1'b0)) begin
                errs++;
                $display("FAIL R2 so_oe act=%b exp=%b", so_oe, exp_oe);
            end
        end
    end

    task automatic xfer(input int n, input logic [63:0] bits);
        logic [15:0] resp;
        logic [15:0] last;
        int          cnt;
        last = '0;
        cnt  = 0;
        resp = {diag_i, readback(m_ptr)};
        exp_so.delete();
        for (int k = 15; k >= 0; k--) exp_so.push_back(resp[k]);
        cmp_en = 1'b0;
        cs_n = 1'b0;
        waitn(8);
        exp_oe = 1'b1;
        cmp_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            logic b, e;
            b = bits[n-1-i];
            si = b;
            waitn(4);
            e = exp_so.pop_front();
            vecs++;
            if (so_d !== e) begin
                errs++;
                if (i < 16) $display("FAIL R7 so bit %0d act=%b exp=%b", i, so_d, e);
                else        $display("FAIL R8 so bit %0d act=%b exp=%b", i, so_d, e);
            end
            // R10: value must hold across the rising edge
            sclk = 1'b1;
            waitn(4);
            chk("R10 so across rise", 32'(so_d), 32'(e));
            waitn(4);
            exp_so.push_back(b);
            last = {last[14:0], b};
            cnt++;
            sclk = 1'b0;
            waitn(8);
        end
        cmp_en = 1'b0;
        cs_n = 1'b1;
        waitn(8);
        if (cnt > 0 && cnt % 16 == 0) begin
            int a;
            a = int'(last[14:12]);
            if (last[15] && a != 0 && a != 6) m_reg[a] = last[7:0];
            m_ptr = a;
        end
        exp_oe = 1'b0;
        cmp_en = 1'b1;
        waitn(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        model_reset();
        waitn(5);
        // R1 defaults while reset held
        chk("R1 map in reset", 32'(map_o), 32'h08);
        chk("R1 ctrl in reset", 32'(ctrl_o), 32'h00);
        rst_n = 1'b1;
        waitn(3);
        chk("R1 map default", 32'(map_o), 32'h08);
        chk("R1 others default", {bool_o, ovld_o, otmp_o}, 32'h0);
        chk("R1 slew default", 32'(slew_o), 32'h0);
        chk("R1 so_oe idle", 32'(so_oe), 32'h0);
        cmp_en = 1'b1;

        diag_i = 8'h3C;
        out_state_i = 8'h81;
        // R3 plain writes; first response reads pointer 000 (R1, R7)
        xfer(16, 64'(frm(1'b1, 7, 4'h0, 8'hA5)));
        chk("R3 ctrl write", 32'(ctrl_o), 32'hA5);
        // R4 reserved bits set
        xfer(16, 64'(frm(1'b1, 1, 4'hF, 8'h3C)));
        chk("R4 map ignores rsvd", 32'(map_o), 32'h3C);
        xfer(16, 64'(frm(1'b1, 2, 4'h5, 8'hC3)));
        xfer(16, 64'(frm(1'b1, 3, 4'h0, 8'h81)));
        xfer(16, 64'(frm(1'b1, 4, 4'h0, 8'h7E)));
        xfer(16, 64'(frm(1'b1, 5, 4'h0, 8'h55)));
        chk("R3 bool", 32'(bool_o), 32'hC3);
        chk("R3 ovld", 32'(ovld_o), 32'h81);
        chk("R3 otmp", 32'(otmp_o), 32'h7E);
        chk("R3 slew", 32'(slew_o), 32'h55);
        // R7 read frames: response carries previous address contents
        xfer(16, 64'(frm(1'b0, 2, 4'h0, 8'hFF)));
        chk("R7 read leaves bool", 32'(bool_o), 32'hC3);
        diag_i = 8'hE1;
        out_state_i = 8'h96;
        // R6 read-only and null address
        xfer(16, 64'(frm(1'b1, 6, 4'h0, 8'hFF)));
        chk("R6 addr 110 no write", {map_o, ctrl_o}, 32'h3CA5);
        xfer(16, 64'(frm(1'b1, 0, 4'h0, 8'hFF)));
        chk("R6 addr 000 no write", {bool_o, slew_o}, 32'hC355);
        xfer(16, 64'(frm(1'b0, 7, 4'h0, 8'h00)));
        // R5 short, long and empty frames
        xfer(15, 64'(frm(1'b1, 7, 4'h0, 8'h00) >> 1));
        chk("R5 15 clocks ignored", 32'(ctrl_o), 32'hA5);
        xfer(17, {47'h0, frm(1'b1, 7, 4'h0, 8'h00), 1'b0});
        chk("R5 17 clocks ignored", 32'(ctrl_o), 32'hA5);
        xfer(0, 64'h0);
        xfer(16, 64'(frm(1'b0, 1, 4'h0, 8'h00)));
        // R8 daisy chain: only last word decoded, first passes through
        xfer(32, {32'h0, frm(1'b1, 5, 4'h0, 8'hFF), frm(1'b1, 7, 4'h0, 8'h0F)});
        chk("R8 chain last word", 32'(ctrl_o), 32'h0F);
        chk("R8 chain first word passed", 32'(slew_o), 32'h55);
        xfer(48, {16'h0, frm(1'b1, 2, 4'h0, 8'h11), frm(1'b0, 3, 4'h0, 8'h22),
                  frm(1'b1, 4, 4'h0, 8'h99)});
        chk("R8 chain of three", 32'(otmp_o), 32'h99);
        xfer(16, 64'(frm(1'b0, 6, 4'h0, 8'h00)));
        // R1 reset mid-run
        cmp_en = 1'b0;
        rst_n = 1'b0;
        waitn(3);
        model_reset();
        chk("R1 map after reset", 32'(map_o), 32'h08);
        chk("R1 ctrl after reset", 32'(ctrl_o), 32'h00);
        rst_n = 1'b1;
        waitn(3);
        cmp_en = 1'b1;
        xfer(16, 64'(frm(1'b1, 1, 4'h0, 8'hF0)));
        chk("R3 write after reset", 32'(map_o), 32'hF0);
        waitn(4);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule